// File: doc/BRIEF.md
# Programmable Pin Toggle Generator

This block produces square-wave stimulus on a small set of input pins. Every pin has a generator of its own. Software picks a pin by index and loads three values: a high hold time, a low hold time (both counted in ticks, where one tick is four clock cycles) and a repeat count. It then issues a start or a clear command.

While a generator is running, it inverts its pin each time the programmed hold time for the current level runs out. When the repeat budget is used up, it stops by itself. The level of each generator is merged into the incoming pin vector. Pins that have never been started pass through unchanged.

A status port shows three things for any pin chosen by index: whether its generator is running, the level it is driving and the ticks left until its next transition. A sticky flag reports a command that named a pin which does not exist.

Top module: `pin_toggle_gen`

## Requirements
- R1: Reset has these effects on every generator:
  - it stops the generator and sets its level to 0;
  - it sets the remaining-tick count to 0 and clears the error flag;
  - it returns every bit of `pin_out` to the matching bit of `pin_in`.
- R2: A start on a valid pin has these effects:
  - from the next cycle, the generator reports active;
  - its remaining-tick count equals the hold time of its present level, where level 1 uses the high hold and level 0 uses the low hold;
  - a programmed hold of 0 is treated as 1.
- R3: One tick occurs every 4 clock cycles. An active generator lowers its remaining-tick count by one on each tick, so over any 8 consecutive cycles the count falls by exactly 2.
- R4: Transitions are spaced by the hold times. A high phase lasts exactly high-hold × 4 cycles and a low phase lasts exactly low-hold × 4 cycles.
- R5: A start with repeat value N gives exactly N+1 transitions. After the last one, the generator reports inactive with a remaining-tick count of 0.
- R6: A clear stops the generator and sets its remaining-tick count to 0. The level is not changed, and the pin goes on driving that level.
- R7: Ownership and isolation of pins:
  - from its first start until the next reset, bit k of `pin_out` carries the level of generator k;
  - bits of pins never started follow `pin_in`;
  - a run on one pin never changes another pin's bit.
- R8: A start or clear whose pin index is 6 or above (with the default of 6 pins) has these effects:
  - no generator changes;
  - `err_bad_pin` is set, and stays set until a command with a valid index arrives;
  - a status query with an invalid index reads all zeros.
- R9: A start that arrives in the same cycle as a due transition on the same pin has these effects:
  - the start wins and the transition is dropped;
  - the count reloads from the unchanged level.
- R10: A start and a clear for the same pin in the same cycle act as a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse for pin `cmd_pin` |
| cmd_clear | input | 1 | Clear pulse for pin `cmd_pin` |
| cmd_pin | input | PIN_IDX_W | Target pin index |
| cmd_on | input | CNT_W | High hold time in ticks |
| cmd_off | input | CNT_W | Low hold time in ticks |
| cmd_repeat | input | REP_W | Repeat count (transitions = value + 1) |
| pin_in | input | NUM_PINS | External input pin values |
| pin_out | output | NUM_PINS | Pin values with generator levels merged |
| stat_pin | input | PIN_IDX_W | Pin index for status query |
| stat_active | output | 1 | Selected generator running |
| stat_level | output | 1 | Selected generator level |
| stat_remain | output | CNT_W | Ticks left to the next transition |
| err_bad_pin | output | 1 | Last command named a missing pin |

## Verification
The case that needs care is a start command landing on the very tick where the same generator's transition falls due. To provoke it, the bench programs a one-tick hold and holds `cmd_start` high for 24 consecutive cycles. Every tick in that window then collides with a command. The bench judges the result from the ports: the pin bit must never move and the remaining count must read 1 on every cycle. Once the command is released, a transition must follow within two ticks. A second collision is tested too: a start and a clear issued together must leave the generator idle.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  // Hold time with the one-tick floor applied.
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Ticks to hold for a given level.
  function automatic int unsigned hold_ticks(input logic lvl,
                                             input int unsigned hi_t,
                                             input int unsigned lo_t);
    return lvl ? hi_t : lo_t;
  endfunction

endpackage

// File: rtl/ptg_tick_div.sv
module ptg_tick_div #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] ph_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          ph_q <= '0;
        else if (ph_q == DW'(TICK_DIV - 1))  ph_q <= '0;
        else                                 ph_q <= ph_q + 1'b1;
      end
      assign tick = (ph_q == DW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
  import ptg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             clear,
  input  logic [CNT_W-1:0] on_in,
  input  logic [CNT_W-1:0] off_in,
  input  logic [REP_W-1:0] rep_in,
  output logic             active,
  output logic             level,
  output logic             owned,
  output logic             fire,
  output logic [CNT_W-1:0] remain
);
  logic [CNT_W-1:0] on_q, off_q, cnt_q;
  logic [REP_W-1:0] rep_q;
  logic             act_q, lvl_q, own_q;

  logic [CNT_W-1:0] on_c, off_c, start_hold, next_hold;

  assign on_c       = CNT_W'(at_least_one(32'(on_in)));
  assign off_c      = CNT_W'(at_least_one(32'(off_in)));
  assign start_hold = CNT_W'(hold_ticks(lvl_q, 32'(on_c), 32'(off_c)));
  assign next_hold  = CNT_W'(hold_ticks(!lvl_q, 32'(on_q), 32'(off_q)));

  // Transition due this cycle; any command on this pin overrides it.
  assign fire = act_q & tick & (cnt_q == CNT_W'(1)) & ~start & ~clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lvl_q <= 1'b0;
      own_q <= 1'b0;
      cnt_q <= '0;
      rep_q <= '0;
      on_q  <= CNT_W'(1);
      off_q <= CNT_W'(1);
    end else if (clear) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      rep_q <= '0;
    end else if (start) begin
      on_q  <= on_c;
      off_q <= off_c;
      rep_q <= rep_in;
      cnt_q <= start_hold;
      act_q <= 1'b1;
      own_q <= 1'b1;
    end else if (fire) begin
      lvl_q <= ~lvl_q;
      if (rep_q != '0) begin
        rep_q <= rep_q - 1'b1;
        cnt_q <= next_hold;
      end else begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end
    end else if (act_q && tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = act_q;
  assign level  = lvl_q;
  assign owned  = own_q;
  assign remain = cnt_q;
endmodule

// File: rtl/ptg_status_mux.sv
module ptg_status_mux #(
  parameter int NUM_PINS  = 6,
  parameter int PIN_IDX_W = 3,
  parameter int CNT_W     = 16
) (
  input  logic [PIN_IDX_W-1:0]      sel,
  input  logic [NUM_PINS-1:0]       act_v,
  input  logic [NUM_PINS-1:0]       lvl_v,
  input  logic [NUM_PINS*CNT_W-1:0] rem_v,
  output logic                      o_active,
  output logic                      o_level,
  output logic [CNT_W-1:0]          o_remain
);
  logic sel_ok;
  int   idx;

  assign idx    = int'(sel);
  assign sel_ok = (idx < NUM_PINS);

  always_comb begin
    o_active = 1'b0;
    o_level  = 1'b0;
    o_remain = '0;
    if (sel_ok) begin
      o_active = act_v[idx];
      o_level  = lvl_v[idx];
      o_remain = rem_v[idx*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/pin_toggle_gen.sv
module pin_toggle_gen #(
  parameter int NUM_PINS  = 6,
  parameter int PIN_IDX_W = 3,
  parameter int CNT_W     = 16,
  parameter int REP_W     = 16,
  parameter int TICK_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_start,
  input  logic                 cmd_clear,
  input  logic [PIN_IDX_W-1:0] cmd_pin,
  input  logic [CNT_W-1:0]     cmd_on,
  input  logic [CNT_W-1:0]     cmd_off,
  input  logic [REP_W-1:0]     cmd_repeat,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  input  logic [PIN_IDX_W-1:0] stat_pin,
  output logic                 stat_active,
  output logic                 stat_level,
  output logic [CNT_W-1:0]     stat_remain,
  output logic                 err_bad_pin
);
  logic                      tick;
  logic                      pin_ok;
  logic [NUM_PINS-1:0]       gen_active, gen_level, gen_owned, gen_fire;
  logic [NUM_PINS*CNT_W-1:0] gen_remain;
  logic                      err_q;

  assign pin_ok = (int'(cmd_pin) < NUM_PINS);

  ptg_tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  generate
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_ch
      logic hit;
      assign hit = pin_ok && (cmd_pin == PIN_IDX_W'(k));

      ptg_channel #(.CNT_W(CNT_W), .REP_W(REP_W)) u_ch (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (cmd_start & hit),
        .clear (cmd_clear & hit),
        .on_in (cmd_on),
        .off_in(cmd_off),
        .rep_in(cmd_repeat),
        .active(gen_active[k]),
        .level (gen_level[k]),
        .owned (gen_owned[k]),
        .fire  (gen_fire[k]),
        .remain(gen_remain[k*CNT_W +: CNT_W])
      );

      assign pin_out[k] = gen_owned[k] ? gen_level[k] : pin_in[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                     err_q <= 1'b0;
    else if (cmd_start | cmd_clear) err_q <= ~pin_ok;
  end
  assign err_bad_pin = err_q;

  ptg_status_mux #(
    .NUM_PINS(NUM_PINS), .PIN_IDX_W(PIN_IDX_W), .CNT_W(CNT_W)
  ) u_stat (
    .sel     (stat_pin),
    .act_v   (gen_active),
    .lvl_v   (gen_level),
    .rem_v   (gen_remain),
    .o_active(stat_active),
    .o_level (stat_level),
    .o_remain(stat_remain)
  );
endmodule

// File: rtl/ptg_chk.sv
module ptg_chk #(
  parameter int NUM_PINS  = 6,
  parameter int PIN_IDX_W = 3,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_start,
  input logic                 cmd_clear,
  input logic [PIN_IDX_W-1:0] cmd_pin,
  input logic                 tick,
  input logic [NUM_PINS-1:0]  gen_active,
  input logic [NUM_PINS-1:0]  gen_level,
  input logic [NUM_PINS-1:0]  gen_owned,
  input logic [NUM_PINS-1:0]  gen_fire,
  input logic                 stat_active,
  input logic [CNT_W-1:0]     stat_remain,
  input logic                 err_bad_pin
);
  logic cmd_ok;
  assign cmd_ok = (int'(cmd_pin) < NUM_PINS);

  // R3
  fire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gen_fire) |-> tick);

  // R4
  level_moves_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_level ^ $past(gen_level)) == $past(gen_fire));

  // R2
  active_has_remain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_active |-> (stat_remain != '0));

  // R2
  start_goes_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_clear && cmd_ok) |=>
      ((gen_active & (NUM_PINS'(1) << $past(cmd_pin))) != '0));

  // R6
  clear_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && cmd_ok) |=>
      ((gen_active & (NUM_PINS'(1) << $past(cmd_pin))) == '0));

  // R6
  clear_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && cmd_ok) |=>
      (((gen_level ^ $past(gen_level)) & (NUM_PINS'(1) << $past(cmd_pin))) == '0));

  // R7
  owned_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_owned) & ~gen_owned) == '0);

  // R8
  bad_pin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_start || cmd_clear) && !cmd_ok) |=> err_bad_pin);
endmodule

bind pin_toggle_gen ptg_chk #(
  .NUM_PINS(NUM_PINS), .PIN_IDX_W(PIN_IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .cmd_clear  (cmd_clear),
  .cmd_pin    (cmd_pin),
  .tick       (tick),
  .gen_active (gen_active),
  .gen_level  (gen_level),
  .gen_owned  (gen_owned),
  .gen_fire   (gen_fire),
  .stat_active(stat_active),
  .stat_remain(stat_remain),
  .err_bad_pin(err_bad_pin)
);

// File: tb/pin_toggle_gen_tb_top.sv
module pin_toggle_gen_tb_top;
  localparam int NP = 6;
  localparam int IW = 3;
  localparam int CW = 16;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0, cmd_clear = 1'b0;
  logic [IW-1:0] cmd_pin = '0;
  logic [CW-1:0] cmd_on = '0, cmd_off = '0;
  logic [RW-1:0] cmd_repeat = '0;
  logic [NP-1:0] pin_in = 6'b101101;
  logic [NP-1:0] pin_out;
  logic [IW-1:0] stat_pin = '0;
  logic          stat_active, stat_level, err_bad_pin;
  logic [CW-1:0] stat_remain;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_toggle_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_clear(cmd_clear),
    .cmd_pin(cmd_pin), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_repeat(cmd_repeat), .pin_in(pin_in), .pin_out(pin_out),
    .stat_pin(stat_pin), .stat_active(stat_active), .stat_level(stat_level),
    .stat_remain(stat_remain), .err_bad_pin(err_bad_pin)
  );

  // pin, high hold, low hold, repeat
  localparam int VEC [6][4] = '{
    '{0, 2, 3, 3}, '{1, 1, 1, 4}, '{2, 0, 2, 2},
    '{5, 3, 0, 1}, '{3, 4, 1, 0}, '{4, 1, 5, 5}
  };

  function automatic int floor1(input int v);
    if (v < 1) return 1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit s, input bit c, input int pin,
                       input int on, input int off, input int rep);
    @(negedge clk);
    cmd_start = s; cmd_clear = c; cmd_pin = IW'(pin);
    cmd_on = CW'(on); cmd_off = CW'(off); cmd_repeat = RW'(rep);
    @(negedge clk);
    cmd_start = 1'b0; cmd_clear = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int          nact;
    logic        lvl;
    logic [NP-1:0] snap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(pin_out == pin_in, "R1 pin_out", int'(pin_out), int'(pin_in));
    chk(!stat_active && stat_remain == 0, "R1 idle", int'(stat_remain), 0);
    chk(!err_bad_pin, "R1 err", int'(err_bad_pin), 0);
    // R7 unowned pins follow pin_in
    pin_in = 6'b010011; #1;
    chk(pin_out == pin_in, "R7 passthrough", int'(pin_out), int'(pin_in));

    // Table of waveform runs: R2 R4 R5 R7
    for (int i = 0; i < 6; i++) begin
      int p, eon, eoff, rep, tog, last, bad, badw, badx;
      logic cur;
      logic [NP-1:0] others;
      p = VEC[i][0]; eon = floor1(VEC[i][1]); eoff = floor1(VEC[i][2]); rep = VEC[i][3];
      stat_pin = IW'(p); #1;
      lvl = stat_level;
      issue(1'b1, 1'b0, p, VEC[i][1], VEC[i][2], rep);
      chk(stat_active, "R2 active", int'(stat_active), 1);
      chk(int'(stat_remain) == (lvl ? eon : eoff), "R2 reload",
          int'(stat_remain), lvl ? eon : eoff);
      chk(pin_out[p] == lvl, "R7 owned level", int'(pin_out[p]), int'(lvl));
      others = pin_out & ~(NP'(1) << p);
      cur = pin_out[p]; tog = 0; last = -1; bad = 0; badw = 0; badx = 0;
      for (int cyc = 0; cyc < 2000; cyc++) begin
        @(negedge clk); #1;
        if (pin_out[p] != cur) begin
          if (last >= 0 && (cyc - last) != (cur ? eon * 4 : eoff * 4)) begin
            bad++; badw = cyc - last; badx = cur ? eon * 4 : eoff * 4;
          end
          tog++; last = cyc; cur = pin_out[p];
        end
        if (!stat_active) break;
      end
      chk(bad == 0, "R4 phase width", badw, badx);
      chk(tog == rep + 1, "R5 transitions", tog, rep + 1);
      chk(stat_remain == 0 && !stat_active, "R5 stopped", int'(stat_remain), 0);
      chk((pin_out & ~(NP'(1) << p)) == others, "R7 isolation",
          int'(pin_out & ~(NP'(1) << p)), int'(others));
    end

    // R3 tick rate
    stat_pin = IW'(0);
    issue(1'b1, 1'b0, 0, 10, 10, 100);
    chk(stat_remain == 10, "R3 reload", int'(stat_remain), 10);
    repeat (8) @(negedge clk); #1;
    chk(stat_remain == 8, "R3 two ticks in 8 cycles", int'(stat_remain), 8);

    // R6 clear keeps level
    lvl = stat_level;
    issue(1'b0, 1'b1, 0, 0, 0, 0);
    chk(!stat_active && stat_remain == 0, "R6 stopped", int'(stat_remain), 0);
    chk(stat_level == lvl && pin_out[0] == lvl, "R6 level kept", int'(pin_out[0]), int'(lvl));
    repeat (20) @(negedge clk); #1;
    chk(pin_out[0] == lvl, "R6 level held", int'(pin_out[0]), int'(lvl));

    // R8 bad index
    snap = pin_out;
    issue(1'b1, 1'b0, 6, 1, 1, 5);
    chk(err_bad_pin, "R8 err set", int'(err_bad_pin), 1);
    nact = 0;
    for (int k = 0; k < NP; k++) begin
      stat_pin = IW'(k); #1;
      if (stat_active) nact++;
    end
    chk(nact == 0, "R8 nothing started", nact, 0);
    repeat (12) @(negedge clk); #1;
    chk(pin_out == snap, "R8 pins unchanged", int'(pin_out), int'(snap));
    stat_pin = IW'(6); #1;
    chk(!stat_active && !stat_level && stat_remain == 0, "R8 bad status",
        int'(stat_remain), 0);
    issue(1'b0, 1'b1, 3, 0, 0, 0);
    chk(!err_bad_pin, "R8 err cleared", int'(err_bad_pin), 0);

    // R9 command collides with due transition
    stat_pin = IW'(1);
    issue(1'b1, 1'b0, 1, 1, 1, 50);
    lvl = pin_out[1];
    @(negedge clk);
    cmd_start = 1'b1; cmd_pin = IW'(1);
    nact = 0;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk); #1;
      if (pin_out[1] != lvl || stat_remain != 1) nact++;
    end
    cmd_start = 1'b0;
    chk(nact == 0, "R9 start beats transition", nact, 0);
    repeat (9) @(negedge clk); #1;
    chk(pin_out[1] != lvl, "R9 resumes after release", int'(pin_out[1]), int'(!lvl));

    // R10 start and clear together
    stat_pin = IW'(2);
    issue(1'b1, 1'b1, 2, 5, 5, 9);
    chk(!stat_active, "R10 clear wins", int'(stat_active), 0);

    // R1 reset in mid-run
    stat_pin = IW'(4);
    issue(1'b1, 1'b0, 4, 3, 3, 40);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    chk(pin_out == pin_in, "R1 reset pins", int'(pin_out), int'(pin_in));
    nact = 0;
    for (int k = 0; k < NP; k++) begin
      stat_pin = IW'(k); #1;
      if (stat_active || stat_level || stat_remain != 0) nact++;
    end
    chk(nact == 0, "R1 reset generators", nact, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule